// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a processor core and a byte-addressed memory that is 32 bits wide. For each access it forms the effective byte address from a base register value and a signed 16-bit displacement. For stores it places the outgoing byte or halfword on the correct byte lanes and raises the matching write strobes. For loads it selects the addressed lanes of the returned memory word and widens the value to 32 bits, using either sign or zero extension.

Lanes follow big-endian order. The byte at the lowest address of a word travels on the most significant lane. An access whose address does not suit its size is flagged as misaligned. A misaligned access produces no strobes and no data. All outputs are registered, so the results for the inputs presented before a rising clock edge appear just after that edge.

Top module: `be_ldst_align`

## Requirements
- R1: A synchronous active-low reset clears every output (memory address, strobes, write word, load result and misalignment flag) to zero at the next rising edge.
- R2: The effective address is the base plus the 16-bit displacement sign-extended to 32 bits. The address output is that sum with bits 1:0 forced to zero. Every output reflects the inputs sampled at the previous rising edge.
- R3: The size code is 2'b00 for a byte, 2'b01 for a halfword and 2'b10 for a word. Code 2'b11 acts exactly like a word. A halfword whose effective address has bit 0 set is misaligned. A word whose effective address has bits 1:0 nonzero is misaligned. In both cases the misalignment flag is 1, and otherwise it is 0.
- R4: On a misaligned access the strobes, the write word and the load result are all zero.
- R5: On a byte store at word offset k (the effective address bits 1:0), the write word holds the low store byte copied into all four lanes. Only strobe bit 3-k is set. Strobe bit i covers write word bits [8i+7:8i].
- R6: On a halfword store the write word holds the low 16 store bits in both halves. The strobes are 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R7: On a word store the write word equals the store data and the strobes are 4'b1111.
- R8: On a load the strobes and the write word are zero. On a store the load result is zero.
- R9: A byte load at offset k takes read word bits [31-8k:24-8k]. When the unsigned select is 0, bit 7 of that byte is copied into bits 31:8. When it is 1, bits 31:8 are zero.
- R10: A halfword load takes read bits [31:16] at offset 0 and bits [15:0] at offset 2. It is sign- or zero-extended by the same select as in R9.
- R11: A word load returns the read word unchanged, whatever the unsigned select.
- R12: A negative displacement lowers the address, and the addition wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| base_addr | input | 32 | Base register value |
| disp | input | 16 | Signed byte displacement |
| acc_size | input | 2 | Access size code |
| is_unsigned | input | 1 | 1 selects zero extension on loads |
| is_store | input | 1 | 1 for a store, 0 for a load |
| st_data | input | 32 | Store data, right-justified |
| rd_word | input | 32 | Word read from memory |
| mem_addr | output | 32 | Word-aligned memory address |
| byte_en | output | 4 | Write strobe per byte lane |
| wr_word | output | 32 | Lane-positioned write data |
| ld_result | output | 32 | Extended load value |
| misalign | output | 1 | Access violates its alignment |

## Verification
A wrong lane index or a reversed byte order shows up in the very next cycle. It appears either as a strobe pattern on the wrong end of the word or as a load result taken from the mirror-image byte. Sign handling that goes wrong shows in the upper bits of the load result in that same cycle, but only when the selected byte or halfword has its top bit set. The load patterns therefore mix set and clear top bits. A faulty alignment decision shows at once as strobes that appear on a bad address, or that vanish on a good one. Negative displacements check the carry and wrap of the address add.

// File: rtl/lsa_pkg.sv
// Package: shared size codes and helpers for the load/store lane aligner.
// Assumes a data path of a whole number of 8-bit lanes.
package lsa_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

    localparam int LANE_W = 8;

    // True when the code denotes a full-word access.
    function automatic logic is_word(input acc_size_e sz);
        return sz[1];
    endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
// Module: effective address and alignment check.
// Adds a sign-extended displacement to the base, exposes the lane offset
// within the word and flags accesses whose address does not suit their size.
// Assumes ADDR_W >= DISP_W and a power-of-two lane count.
module lsa_addr_gen
    import lsa_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DISP_W    = 16,
    parameter int NUM_LANES = 4
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DISP_W-1:0] disp,
    input  acc_size_e         acc_size,
    output logic [ADDR_W-1:0] word_addr,
    output logic [$clog2(NUM_LANES)-1:0] lane_off,
    output logic              misalign
);
    localparam int OFF_W = $clog2(NUM_LANES);

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] eff_addr;

    // Widen the displacement by copying its sign bit.
    always_comb begin
        disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    end

    // Form the byte address and split it into word and lane parts.
    always_comb begin
        eff_addr  = base_addr + disp_ext;
        lane_off  = eff_addr[OFF_W-1:0];
        word_addr = {eff_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    // Decide whether the lane offset is legal for the requested size.
    always_comb begin
        unique case (acc_size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = lane_off[0];
            default: misalign = |lane_off;
        endcase
    end

endmodule

// File: rtl/lsa_store_lanes.sv
// Module: store lane steering.
// Copies the right-justified store value into every lane it may occupy and
// raises the strobes of the lanes that the address selects, lowest address
// on the most significant lane. Assumes the access was checked for alignment.
module lsa_store_lanes
    import lsa_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0]            st_data,
    input  acc_size_e                    acc_size,
    input  logic [$clog2(NUM_LANES)-1:0] lane_off,
    input  logic                         enable,
    output logic [NUM_LANES-1:0]         byte_en,
    output logic [DATA_W-1:0]            wr_word
);
    localparam int OFF_W = $clog2(NUM_LANES);

    // Lane number that carries the addressed byte (mirror of the offset).
    logic [OFF_W-1:0] top_lane;

    // Map the address offset onto the big-endian lane number.
    always_comb begin
        top_lane = ~lane_off;
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_ID = OFF_W'(i);
        logic hit;

        // Decide whether lane i is written by this access.
        always_comb begin
            unique case (acc_size)
                SZ_BYTE: hit = (LANE_ID == top_lane);
                SZ_HALF: hit = (LANE_ID[OFF_W-1:1] == top_lane[OFF_W-1:1]);
                default: hit = 1'b1;
            endcase
            byte_en[i] = enable & hit;
        end

        // Pick the store byte that belongs on lane i.
        always_comb begin
            if (!enable) begin
                wr_word[i*LANE_W +: LANE_W] = '0;
            end else begin
                unique case (acc_size)
                    SZ_BYTE: wr_word[i*LANE_W +: LANE_W] = st_data[LANE_W-1:0];
                    SZ_HALF: wr_word[i*LANE_W +: LANE_W] =
                                 st_data[(i % 2)*LANE_W +: LANE_W];
                    default: wr_word[i*LANE_W +: LANE_W] = st_data[i*LANE_W +: LANE_W];
                endcase
            end
        end
    end

endmodule

// File: rtl/lsa_load_extend.sv
// Module: load lane selection and extension.
// Selects the addressed byte or halfword from the read word under
// big-endian order and widens it with sign or zero fill.
// Assumes the access was checked for alignment.
module lsa_load_extend
    import lsa_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0]            rd_word,
    input  acc_size_e                    acc_size,
    input  logic [$clog2(NUM_LANES)-1:0] lane_off,
    input  logic                         is_unsigned,
    input  logic                         enable,
    output logic [DATA_W-1:0]            ld_result
);
    localparam int OFF_W  = $clog2(NUM_LANES);
    localparam int HALF_W = 2 * LANE_W;

    logic [OFF_W-1:0]  byte_lane;
    logic [OFF_W-2:0]  half_idx;
    logic [LANE_W-1:0] sel_byte;
    logic [HALF_W-1:0] sel_half;
    logic              fill_b;
    logic              fill_h;

    // Mirror the offset to find the lane and halfword holding the data.
    always_comb begin
        byte_lane = ~lane_off;
        half_idx  = ~lane_off[OFF_W-1:1];
    end

    // Extract the candidate byte and halfword from the read word.
    always_comb begin
        sel_byte = rd_word[byte_lane*LANE_W +: LANE_W];
        sel_half = rd_word[half_idx*HALF_W +: HALF_W];
        fill_b   = ~is_unsigned & sel_byte[LANE_W-1];
        fill_h   = ~is_unsigned & sel_half[HALF_W-1];
    end

    // Widen the value chosen by the access size.
    always_comb begin
        if (!enable) begin
            ld_result = '0;
        end else begin
            unique case (acc_size)
                SZ_BYTE: ld_result = {{(DATA_W-LANE_W){fill_b}}, sel_byte};
                SZ_HALF: ld_result = {{(DATA_W-HALF_W){fill_h}}, sel_half};
                default: ld_result = rd_word;
            endcase
        end
    end

endmodule

// File: rtl/be_ldst_align.sv
// Module: big-endian load/store lane aligner, top level.
// Combines the address, store and load paths and registers every output,
// so results appear one clock after their inputs. Assumes a memory that
// is byte-addressed and DATA_W bits wide.
module be_ldst_align
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DISP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [DISP_W-1:0]    disp,
    input  logic [1:0]           acc_size,
    input  logic                 is_unsigned,
    input  logic                 is_store,
    input  logic [DATA_W-1:0]    st_data,
    input  logic [DATA_W-1:0]    rd_word,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W/8-1:0]  byte_en,
    output logic [DATA_W-1:0]    wr_word,
    output logic [DATA_W-1:0]    ld_result,
    output logic                 misalign
);
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int OFF_W     = $clog2(NUM_LANES);

    acc_size_e             size_q;
    logic [ADDR_W-1:0]     word_addr_c;
    logic [OFF_W-1:0]      lane_off_c;
    logic                  misalign_c;
    logic [NUM_LANES-1:0]  byte_en_c;
    logic [DATA_W-1:0]     wr_word_c;
    logic [DATA_W-1:0]     ld_result_c;
    logic                  st_go;
    logic                  ld_go;

    // Interpret the raw size code as the shared enumeration.
    always_comb begin
        size_q = acc_size_e'(acc_size);
        st_go  = is_store & ~misalign_c;
        ld_go  = ~is_store & ~misalign_c;
    end

    lsa_addr_gen #(
        .ADDR_W    (ADDR_W),
        .DISP_W    (DISP_W),
        .NUM_LANES (NUM_LANES)
    ) u_addr (
        .base_addr (base_addr),
        .disp      (disp),
        .acc_size  (size_q),
        .word_addr (word_addr_c),
        .lane_off  (lane_off_c),
        .misalign  (misalign_c)
    );

    lsa_store_lanes #(
        .DATA_W    (DATA_W),
        .NUM_LANES (NUM_LANES)
    ) u_store (
        .st_data  (st_data),
        .acc_size (size_q),
        .lane_off (lane_off_c),
        .enable   (st_go),
        .byte_en  (byte_en_c),
        .wr_word  (wr_word_c)
    );

    lsa_load_extend #(
        .DATA_W    (DATA_W),
        .NUM_LANES (NUM_LANES)
    ) u_load (
        .rd_word     (rd_word),
        .acc_size    (size_q),
        .lane_off    (lane_off_c),
        .is_unsigned (is_unsigned),
        .enable      (ld_go),
        .ld_result   (ld_result_c)
    );

    // Capture the combined results, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            byte_en   <= '0;
            wr_word   <= '0;
            ld_result <= '0;
            misalign  <= 1'b0;
        end else begin
            mem_addr  <= word_addr_c;
            byte_en   <= byte_en_c;
            wr_word   <= wr_word_c;
            ld_result <= ld_result_c;
            misalign  <= misalign_c;
        end
    end

    // A flagged access must leave strobes and load data empty.
    p_quiet_on_misalign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (byte_en == '0) && (ld_result == '0));

    // Loads never drive strobes or write data.
    p_load_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_store |=> (byte_en == '0) && (wr_word == '0));

    // A byte store touches exactly one lane unless it was rejected.
    p_byte_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && acc_size == SZ_BYTE) |=> ($countones(byte_en) == 1));

    // An accepted halfword store touches exactly two lanes.
    p_half_two_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && acc_size == SZ_HALF) |=> misalign || ($countones(byte_en) == 2));

    // Unsigned byte loads leave the upper bits clear.
    p_ubyte_zero_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_store && is_unsigned && acc_size == SZ_BYTE) |=>
            (ld_result[DATA_W-1:LANE_W] == '0));

    // An accepted word load passes the read word through.
    p_word_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_store && acc_size[1]) |=> misalign || (ld_result == $past(rd_word)));

endmodule

// File: tb/test_be_ldst_align.sv
// Scoreboard bench: the driver pushes predicted outputs, the monitor pops
// and compares one cycle later, just after the capturing edge.
module test_be_ldst_align;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wr;
        logic [31:0] ld;
        logic        mis;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] disp = '0;
    logic [1:0]  acc_size = '0;
    logic        is_unsigned = 1'b0;
    logic        is_store = 1'b0;
    logic [31:0] st_data = '0;
    logic [31:0] rd_word = '0;
    logic [31:0] mem_addr;
    logic [3:0]  byte_en;
    logic [31:0] wr_word;
    logic [31:0] ld_result;
    logic        misalign;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    be_ldst_align i_be_ldst_align (
        .clk, .rst_n, .base_addr, .disp, .acc_size, .is_unsigned, .is_store,
        .st_data, .rd_word, .mem_addr, .byte_en, .wr_word, .ld_result, .misalign
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference prediction written from the requirement text.
    function automatic exp_t predict(input logic [31:0] b, input logic [15:0] d,
                                     input logic [1:0] sz, input logic u,
                                     input logic st, input logic [31:0] sd,
                                     input logic [31:0] rd, input string tag);
        exp_t e;
        logic [31:0] ea;
        logic [7:0]  by;
        logic [15:0] hw;
        ea  = b + {{16{d[15]}}, d};
        e.addr = {ea[31:2], 2'b00};
        e.tag  = tag;
        e.be = '0; e.wr = '0; e.ld = '0;
        e.mis = (sz == 2'b01 && ea[0]) || (sz[1] && ea[1:0] != 2'b00);
        if (!e.mis) begin
            if (st) begin
                case (sz)
                    2'b00: begin e.be = 4'b1000 >> ea[1:0]; e.wr = {4{sd[7:0]}}; end
                    2'b01: begin e.be = ea[1] ? 4'b0011 : 4'b1100; e.wr = {2{sd[15:0]}}; end
                    default: begin e.be = 4'b1111; e.wr = sd; end
                endcase
            end else begin
                case (sz)
                    2'b00: begin
                        case (ea[1:0])
                            2'd0: by = rd[31:24];
                            2'd1: by = rd[23:16];
                            2'd2: by = rd[15:8];
                            default: by = rd[7:0];
                        endcase
                        e.ld = u ? {24'h0, by} : {{24{by[7]}}, by};
                    end
                    2'b01: begin
                        hw = ea[1] ? rd[15:0] : rd[31:16];
                        e.ld = u ? {16'h0, hw} : {{16{hw[15]}}, hw};
                    end
                    default: e.ld = rd;
                endcase
            end
        end
        return e;
    endfunction

    // Present one access on a falling edge and queue its prediction.
    task automatic drive(input logic [31:0] b, input logic [15:0] d,
                         input logic [1:0] sz, input logic u, input logic st,
                         input logic [31:0] sd, input logic [31:0] rd,
                         input string tag);
        @(negedge clk);
        base_addr = b; disp = d; acc_size = sz; is_unsigned = u;
        is_store = st; st_data = sd; rd_word = rd;
        sb_q.push_back(predict(b, d, sz, u, st, sd, rd, tag));
    endtask

    // Compare one observed field set against a prediction.
    task automatic compare(input exp_t e);
        n_checks++;
        if (mem_addr !== e.addr || byte_en !== e.be || wr_word !== e.wr ||
            ld_result !== e.ld || misalign !== e.mis) begin
            n_fails++;
            $display("FAIL %s: got addr=%h be=%b wr=%h ld=%h mis=%b exp addr=%h be=%b wr=%h ld=%h mis=%b",
                     e.tag, mem_addr, byte_en, wr_word, ld_result, misalign,
                     e.addr, e.be, e.wr, e.ld, e.mis);
        end
    endtask

    // Monitor: just after each rising edge, check the oldest prediction.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    // Check the all-zero reset state (R1).
    task automatic check_reset(input string tag);
        exp_t z;
        z.addr = '0; z.be = '0; z.wr = '0; z.ld = '0; z.mis = 1'b0; z.tag = tag;
        compare(z);
    endtask

    initial begin
        rst_n = 1'b0;
        base_addr = 32'h1234_5671; acc_size = 2'b10; is_store = 1'b1;
        st_data = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1 check_reset("R1 power-up");
        @(negedge clk) rst_n = 1'b1;

        drive(32'h0000_1000, 16'h0020, 2'b10, 0, 1, 32'hCAFE_F00D, 0, "R7 R2 word store");
        for (int k = 0; k < 4; k++)
            drive(32'h0000_2000, 16'(k), 2'b00, 0, 1, 32'h1122_33A5, 0, "R5 byte store");
        drive(32'h0000_3000, 16'h0000, 2'b01, 0, 1, 32'h1234_BEEF, 0, "R6 half store off0");
        drive(32'h0000_3000, 16'h0002, 2'b01, 0, 1, 32'h1234_BEEF, 0, "R6 half store off2");
        drive(32'h0000_3000, 16'h0001, 2'b01, 0, 1, 32'h1234_BEEF, 0, "R3 R4 half store odd");
        drive(32'h0000_3000, 16'h0002, 2'b10, 0, 1, 32'h1234_BEEF, 0, "R3 R4 word store off2");
        drive(32'h0000_0100, 16'hFFFC, 2'b10, 0, 1, 32'h0BAD_0BAD, 0, "R12 negative disp");
        drive(32'h0000_0000, 16'h8000, 2'b00, 0, 1, 32'h0000_0077, 0, "R12 wrap below zero");
        drive(32'h7FFF_FFFE, 16'h0003, 2'b00, 0, 0, 0, 32'h0102_0304, "R12 R2 carry");
        for (int k = 0; k < 4; k++) begin
            drive(32'h0000_4000, 16'(k), 2'b00, 0, 0, 0, 32'h80FF_7F01, "R9 signed byte");
            drive(32'h0000_4000, 16'(k), 2'b00, 1, 0, 0, 32'h80FF_7F01, "R9 unsigned byte");
        end
        drive(32'h0000_5000, 16'h0000, 2'b01, 0, 0, 0, 32'h8001_7FFE, "R10 signed half off0");
        drive(32'h0000_5000, 16'h0000, 2'b01, 1, 0, 0, 32'h8001_7FFE, "R10 unsigned half off0");
        drive(32'h0000_5000, 16'h0002, 2'b01, 0, 0, 0, 32'h8001_7FFE, "R10 signed half off2");
        drive(32'h0000_5000, 16'h0002, 2'b01, 0, 0, 0, 32'h8001_FFFE, "R10 negative half off2");
        drive(32'h0000_6000, 16'h0000, 2'b10, 0, 0, 0, 32'hDEAD_BEEF, "R11 word load signed");
        drive(32'h0000_6000, 16'h0000, 2'b10, 1, 0, 0, 32'hDEAD_BEEF, "R11 word load unsigned");
        drive(32'h0000_6000, 16'h0004, 2'b11, 0, 0, 0, 32'h1357_9BDF, "R3 code 11 load");
        drive(32'h0000_6000, 16'h0004, 2'b11, 0, 1, 32'h2468_ACE0, 0, "R3 code 11 store");
        drive(32'h0000_6000, 16'h0003, 2'b01, 0, 0, 0, 32'hFFFF_FFFF, "R4 R8 misaligned load");
        drive(32'h0000_6000, 16'h0001, 2'b10, 1, 0, 0, 32'hFFFF_FFFF, "R4 misaligned word load");
        drive(32'h0000_7000, 16'h0003, 2'b00, 0, 0, 32'hFFFF_FFFF, 32'h0000_00F0, "R8 load ignores store data");
        drive(32'h0000_7000, 16'h0000, 2'b10, 0, 1, 32'h5555_AAAA, 32'hFFFF_FFFF, "R8 store ignores read word");
        // Reset with a live store on the inputs clears the outputs (R1).
        @(negedge clk);
        wait (sb_q.size() == 0);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #2 check_reset("R1 mid-run reset");
        @(negedge clk) rst_n = 1'b1;
        drive(32'h0000_8000, 16'h0001, 2'b00, 0, 1, 32'h0000_003C, 0, "R5 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule